// File: doc/BRIEF.md
# Single-Bin Recursive DFT Engine

This block produces the complex Fourier coefficient of one frequency bin over a frame of signed real samples. Instead of a full transform it runs a two-state resonator: each accepted sample is folded into a pair of state registers through a feedback term built from the bin's cosine. Once the last sample of the frame is in, a short three-cycle finishing step turns the final two states into a real and an imaginary part. A single real multiplier serves both the per-sample feedback and the two finishing products.

The bin is chosen at run time by two signed Q1.14 coefficient inputs, the cosine and the sine of 2πk/N. A tone detector uses eight copies side by side, one per tone frequency. At an 8 kHz sample rate with a 256-sample frame, these are bins 22, 25, 27 and 30 for the low tones and bins 39, 43, 47 and 52 for the high tones. Magnitude estimation and peak picking belong to the stage downstream.

Top module: `rdft_bin`

## Requirements
- R1: While reset is asserted and after it is released, re_o and im_o read zero and done_o and err_o read low.
- R2: Each accepted sample x updates the states as s1 := x + floor(C·s1 / 2^13) − s2 and s2 := old s1, where C is coef_cos as a signed integer (cosine × 16384). Twice the cosine is applied through the shift of 13 rather than 14.
- R3: A sample is taken only in a cycle where in_valid is high and the block is accumulating. Cycles without in_valid leave both states unchanged.
- R4: frame_start while accumulating clears both states and the sample count. If in_valid is high in the same cycle, that sample is taken as index 0 of the new frame.
- R5: A frame is N accepted samples (N = 256 by default). If the last sample is presented in cycle c, the result is complete and done_o is high in cycle c+3.
- R6: re_o = floor(C·s1 / 2^14) − s2 and im_o = floor(S·s1 / 2^14), where S is coef_sin and s1, s2 are the states after the last sample. re_o changes only in cycle c+2, im_o only in cycle c+3, and both hold until the next frame's result.
- R7: done_o is a single-cycle pulse, one per completed frame.
- R8: A sample presented in cycles c+1 to c+3 is discarded and has no effect on any result. err_o goes high for one cycle, in the cycle after each such sample.
- R9: After done_o, the states and count are cleared without any frame_start, so the next frame may follow at once.
- R10: A full-scale tone that sits exactly on the selected bin gives a magnitude within 2% of N·A/2. A tone on a different detection bin gives less than 2% of that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Restart frame: clear states and count |
| in_valid | input | 1 | sample_i carries a sample this cycle |
| sample_i | input | IN_W | Signed input sample |
| coef_cos | input | CF_W | Signed Q1.14 cosine of the bin angle |
| coef_sin | input | CF_W | Signed Q1.14 sine of the bin angle |
| re_o | output | IN_W+log2(N)+2 | Real part of the bin result |
| im_o | output | IN_W+log2(N)+2 | Imaginary part of the bin result |
| done_o | output | 1 | One-cycle pulse when both parts are new |
| err_o | output | 1 | One-cycle pulse: a sample arrived while finishing |

## Verification
Everything depends on the cycle c in which the last sample of a frame is presented. The real part is due in cycle c+2 and the imaginary part and done_o in cycle c+3. An error pulse is due one cycle after any sample that arrives inside the finishing window. The bench keeps a behavioural model that advances on the same edge as the design and compares every output one half period later. On top of that, it counts cycles explicitly after the last sample to check that done_o is low, low, then high, and that err_o rises exactly one cycle after a sample that arrives while the block is busy.

// File: rtl/rdft_bin_pkg.sv
package rdft_bin_pkg;
  typedef enum logic [1:0] {
    PH_ACC  = 2'd0,
    PH_RE   = 2'd1,
    PH_IM   = 2'd2,
    PH_DONE = 2'd3
  } phase_t;
endpackage

// File: rtl/rdft_seq.sv
module rdft_seq
  import rdft_bin_pkg::*;
#(
  parameter int N = 256
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_start,
  input  logic   in_valid,
  output phase_t phase,
  output logic   absorb,
  output logic   clear,
  output logic   err
);
  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  phase_t        phase_nx;
  logic [CW-1:0] cnt, cnt_nx, cnt_eff;
  logic          last, err_nx;

  always_comb begin
    absorb  = in_valid && (phase == PH_ACC);
    clear   = ((phase == PH_ACC) && frame_start) || (phase == PH_DONE);
    cnt_eff = ((phase == PH_ACC) && frame_start) ? '0 : cnt;
    last    = absorb && (cnt_eff == LAST);
    err_nx  = in_valid && (phase != PH_ACC);
    if (absorb)     cnt_nx = last ? '0 : cnt_eff + 1'b1;
    else if (clear) cnt_nx = '0;
    else            cnt_nx = cnt;
    unique case (phase)
      PH_ACC:  phase_nx = last ? PH_RE : PH_ACC;
      PH_RE:   phase_nx = PH_IM;
      PH_IM:   phase_nx = PH_DONE;
      default: phase_nx = PH_ACC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_ACC;
      cnt   <= '0;
      err   <= 1'b0;
    end else begin
      phase <= phase_nx;
      cnt   <= cnt_nx;
      err   <= err_nx;
    end
  end
endmodule

// File: rtl/rdft_mul.sv
module rdft_mul #(
  parameter int SW   = 26,
  parameter int CF_W = 16
) (
  input  logic signed [CF_W-1:0]    coef,
  input  logic signed [SW-1:0]      data,
  output logic signed [SW+CF_W-1:0] prod
);
  always_comb prod = coef * data;
endmodule

// File: rtl/rdft_state.sv
module rdft_state #(
  parameter int SW = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              absorb,
  input  logic signed [SW-1:0] x,
  input  logic signed [SW-1:0] fb,
  output logic signed [SW-1:0] s1,
  output logic signed [SW-1:0] s2
);
  logic signed [SW-1:0] b1, b2, bfb, s1_nx, s2_nx;

  always_comb begin
    b1  = clear ? '0 : s1;
    b2  = clear ? '0 : s2;
    bfb = clear ? '0 : fb;
    if (absorb) begin
      s1_nx = x + bfb - b2;
      s2_nx = b1;
    end else begin
      s1_nx = b1;
      s2_nx = b2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= s1_nx;
      s2 <= s2_nx;
    end
  end
endmodule

// File: rtl/rdft_bin.sv
module rdft_bin
  import rdft_bin_pkg::*;
#(
  parameter int IN_W = 16,
  parameter int N    = 256,
  parameter int CF_W = 16,
  parameter int FRAC = 14
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 frame_start,
  input  logic                                 in_valid,
  input  logic signed [IN_W-1:0]               sample_i,
  input  logic signed [CF_W-1:0]               coef_cos,
  input  logic signed [CF_W-1:0]               coef_sin,
  output logic signed [IN_W+$clog2(N)+1:0]     re_o,
  output logic signed [IN_W+$clog2(N)+1:0]     im_o,
  output logic                                 done_o,
  output logic                                 err_o
);
  localparam int SW = IN_W + $clog2(N) + 2;
  localparam int PW = SW + CF_W;

  phase_t                phase;
  logic                  absorb, clear;
  logic signed [SW-1:0]  st_s1, st_s2, x_ext, fb, oq, re_nx, im_nx;
  logic signed [CF_W-1:0] coef_sel;
  logic signed [PW-1:0]  prod, sh_fb, sh_out;
  logic                  unused_hi;

  rdft_seq #(.N(N)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
    .phase(phase), .absorb(absorb), .clear(clear), .err(err_o)
  );

  // one multiplier: cosine while accumulating and for the real part, sine for the imaginary part
  always_comb coef_sel = (phase == PH_IM) ? coef_sin : coef_cos;

  rdft_mul #(.SW(SW), .CF_W(CF_W)) u_mul (
    .coef(coef_sel), .data(st_s1), .prod(prod)
  );

  always_comb begin
    x_ext     = {{(SW-IN_W){sample_i[IN_W-1]}}, sample_i};
    sh_fb     = prod >>> (FRAC - 1);
    sh_out    = prod >>> FRAC;
    fb        = sh_fb[SW-1:0];
    oq        = sh_out[SW-1:0];
    unused_hi = ^{sh_fb[PW-1:SW], sh_out[PW-1:SW]};
    re_nx     = (phase == PH_RE) ? oq - st_s2 : re_o;
    im_nx     = (phase == PH_IM) ? oq : im_o;
    done_o    = (phase == PH_DONE);
  end

  rdft_state #(.SW(SW)) u_state (
    .clk(clk), .rst_n(rst_n), .clear(clear), .absorb(absorb),
    .x(x_ext), .fb(fb), .s1(st_s1), .s2(st_s2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_o <= '0;
      im_o <= '0;
    end else begin
      re_o <= re_nx;
      im_o <= im_nx;
    end
  end
endmodule

// File: rtl/rdft_bin_chk.sv
module rdft_bin_chk #(
  parameter int SW = 26
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_start,
  input logic                 in_valid,
  input logic [1:0]           phase,
  input logic signed [SW-1:0] s1,
  input logic signed [SW-1:0] s2,
  input logic signed [SW-1:0] re_o,
  input logic signed [SW-1:0] im_o,
  input logic                 done_o,
  input logic                 err_o
);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("R7 done longer than one cycle");

  a_r5_done_after_im: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2) |=> done_o) else $error("R5 done not after imaginary step");

  a_r8_err_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phase != 2'd0) |=> err_o) else $error("R8 missing error pulse");

  a_r8_no_err_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0) |=> !err_o) else $error("R8 spurious error pulse");

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && !in_valid && !frame_start) |=> ($stable(s1) && $stable(s2)))
    else $error("R3 state moved without a sample");

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && frame_start && !in_valid) |=> (s1 == '0 && s2 == '0))
    else $error("R4 states not cleared");

  a_r6_re_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd1) |=> $stable(re_o)) else $error("R6 real part moved");

  a_r6_im_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd2) |=> $stable(im_o)) else $error("R6 imaginary part moved");
endmodule

bind rdft_bin rdft_bin_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
  .phase(phase), .s1(st_s1), .s2(st_s2), .re_o(re_o), .im_o(im_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/rdft_bin_test.sv
`timescale 1ns/1ps
module rdft_bin_test;
  localparam int N  = 256;
  localparam int SW = 16 + 8 + 2;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] sample_i = '0;
  logic signed [15:0] coef_cos = '0;
  logic signed [15:0] coef_sin = '0;
  logic signed [SW-1:0] re_o, im_o;
  logic done_o, err_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit started = 0;
  bit finished = 0;

  // behavioural reference
  int     mph = 0;
  int     mcnt = 0;
  longint ms1 = 0, ms2 = 0, mre = 0, mim = 0;
  bit     merr = 0;

  rdft_bin uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
    .sample_i(sample_i), .coef_cos(coef_cos), .coef_sin(coef_sin),
    .re_o(re_o), .im_o(im_o), .done_o(done_o), .err_o(err_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mph = 0; mcnt = 0; ms1 = 0; ms2 = 0; mre = 0; mim = 0; merr = 0;
    end else begin
      longint t;
      started = 1;
      merr = in_valid && (mph != 0);
      case (mph)
        0: begin
          if (frame_start) begin ms1 = 0; ms2 = 0; mcnt = 0; end
          if (in_valid) begin
            t = longint'(sample_i) + ((longint'(coef_cos) * ms1) >>> 13) - ms2;
            ms2 = ms1; ms1 = t; mcnt++;
            if (mcnt == N) begin mph = 1; mcnt = 0; end
          end
        end
        1: begin mre = ((longint'(coef_cos) * ms1) >>> 14) - ms2; mph = 2; end
        2: begin mim = (longint'(coef_sin) * ms1) >>> 14; mph = 3; end
        default: begin ms1 = 0; ms2 = 0; mcnt = 0; mph = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      chk(re_o == mre, "R6 real part", re_o, mre);
      chk(im_o == mim, "R6 imaginary part", im_o, mim);
      chk(done_o == (mph == 3), "R7 done pulse", done_o, mph == 3);
      chk(err_o == merr, "R8 error pulse", err_o, merr);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic set_bin(input int k);
    real a;
    a = 2.0 * PI * k / N;
    coef_cos = 16'($rtoi($cos(a) * 16384.0 + ($cos(a) >= 0 ? 0.5 : -0.5)));
    coef_sin = 16'($rtoi($sin(a) * 16384.0 + ($sin(a) >= 0 ? 0.5 : -0.5)));
  endtask

  function automatic int tone(input int k, input int n, input real amp);
    return $rtoi(amp * $cos(2.0 * PI * k * n / N));
  endfunction

  // sends samples first..N-1 of a tone, one per cycle; leaves in_valid low after
  task automatic send_tone(input int k, input int first, input real amp);
    for (int n = first; n < N; n++) begin
      in_valid = 1; sample_i = 16'(tone(k, n, amp)); cyc();
    end
    in_valid = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 10 && !done_o; i++) cyc();
  endtask

  real mag_on;

  initial begin
    // R1 reset state
    cyc(); cyc();
    chk(re_o == 0 && im_o == 0, "R1 results zero in reset", re_o, 0);
    chk(!done_o && !err_o, "R1 flags low in reset", {done_o, err_o}, 0);
    rst_n = 1; cyc();
    chk(re_o == 0 && im_o == 0 && !done_o && !err_o, "R1 after release", re_o, 0);

    // Frame A: bin 22 on-bin tone, frame_start with first sample (R4), timing R5
    set_bin(22);
    frame_start = 1; in_valid = 1; sample_i = 16'(tone(22, 0, 30000.0)); cyc();
    frame_start = 0;
    send_tone(22, 1, 30000.0);
    chk(!done_o, "R5 done low at c+1", done_o, 0);
    cyc();
    chk(!done_o, "R5 done low at c+2", done_o, 0);
    chk(re_o == mre, "R5 real part ready at c+2", re_o, mre);
    cyc();
    chk(done_o, "R5 done high at c+3", done_o, 1);
    chk(re_o == mre && im_o == mim, "R2 recursion result frame A", re_o, mre);
    chk(re_o != 0, "R4 first sample absorbed", re_o, mre);
    mag_on = $sqrt($itor(re_o) * $itor(re_o) + $itor(im_o) * $itor(im_o));
    chk(mag_on > 0.98 * N * 15000.0 && mag_on < 1.02 * N * 15000.0,
        "R10 on-bin magnitude", longint'(mag_on), longint'(N * 15000.0));
    cyc();
    chk(!done_o, "R7 done single cycle", done_o, 0);

    // Frame B: no frame_start (R9), off-bin tone 39, sample during finish (R8)
    send_tone(39, 0, 30000.0);
    in_valid = 1; sample_i = 16'sd12345; cyc();
    in_valid = 0;
    chk(err_o, "R8 error one cycle after busy sample", err_o, 1);
    cyc();
    chk(!err_o, "R8 error pulse ends", err_o, 0);
    chk(done_o, "R9 back-to-back frame completes", done_o, 1);
    chk(re_o == mre && im_o == mim, "R9 frame B result", re_o, mre);
    chk($sqrt($itor(re_o) * $itor(re_o) + $itor(im_o) * $itor(im_o)) < 0.02 * mag_on,
        "R10 off-bin rejection", re_o, 0);
    cyc();

    // Frame C: garbage, then frame_start alone (R4), then gapped samples (R3)
    for (int n = 0; n < 10; n++) begin in_valid = 1; sample_i = 16'(n * 997 - 3000); cyc(); end
    in_valid = 0; frame_start = 1; cyc();
    frame_start = 0;
    for (int n = 0; n < N; n++) begin
      in_valid = 1; sample_i = 16'(tone(25, n, 20000.0) + ((n * 37) % 101) - 50); cyc();
      if (n % 3 == 0 && n != N - 1) begin in_valid = 0; sample_i = 16'sd32000; cyc(); cyc(); end
    end
    in_valid = 0;
    wait_done();
    chk(done_o, "R3 gapped frame completes", done_o, 1);
    chk(re_o == mre && im_o == mim, "R3 gapped frame result", re_o, mre);
    cyc();

    // Frame D: high-group bin 47, extreme alternating edges plus tone (R2)
    set_bin(47);
    frame_start = 1; cyc(); frame_start = 0;
    for (int n = 0; n < N; n++) begin
      in_valid = 1;
      sample_i = (n % 17 == 0) ? -16'sd32768 : 16'(tone(47, n, 25000.0));
      cyc();
    end
    in_valid = 0;
    wait_done();
    chk(re_o == mre && im_o == mim, "R2 recursion result frame D", im_o, mim);
    for (int i = 0; i < 6; i++) cyc();
    chk(re_o == mre && im_o == mim, "R6 results held after frame", re_o, mre);

    finish_run();
  end
endmodule